// File: doc/BRIEF.md
# Serial Gain-Control Register Slave

This block is the digital control end of a programmable-gain transmit amplifier. A host reaches it over a three-wire serial link: an active-low select, a serial clock and one data line that both sides share. The block keeps a single 8-bit control word. The upper two bits set the bias level and the lower six bits set the gain step. Both fields are driven straight to the analog core. The host can also read the word back over the same data line. For that, the slave takes the line over part way through the frame.

All three link pins are brought into the system clock domain through a synchronizer. Edges of the serial clock are then detected as one-cycle strobes. A write takes effect only when the twelfth serial clock edge of the frame lands. A write is refused if the transmit-enable input is high at that moment, or if the power-up hold-off counter has not yet expired. The shared data line is split at the port into an input, an output value and an output enable, so that the pad ring can build the tri-state buffer.

Top module: `gainctl_spi_slave`

## Requirements
- R1: A frame is 12 serial clock rising edges while select is low, MSB first. Bit 1 is the direction flag (1 = read, 0 = write), bits 2 to 4 are the register address (A2 first), and bits 5 to 12 are the data byte (D7 first).
- R2: A write to address 0 stores the byte in the control word. Byte bits 7:6 appear on `pwr_lvl_o` and bits 5:0 appear on `gain_lvl_o`.
- R3: The control outputs stay unchanged through the first 11 rising edges of a write frame and change only after the 12th rising edge.
- R4: After reset, `pwr_lvl_o` and `gain_lvl_o` are 0 and `sdio_oe_o` is 0.
- R5: A write frame whose 12th edge arrives while `tx_en_i` is high leaves the control word unchanged.
- R6: For the first `HOLDOFF_CYCLES` system clocks after reset, a write frame leaves the control word unchanged.
- R7: In a read frame the slave holds `sdio_oe_o` low through the 4th rising edge. It raises `sdio_oe_o` on the falling edge after the 4th rising edge and presents D7. On each later falling edge it moves to the next bit, so the master samples D7..D0 on rising edges 5 to 12.
- R8: `sdio_oe_o` returns to 0 once select goes high.
- R9: A read of any address other than 0 returns 0x00. A write to any address other than 0 leaves the control word unchanged.
- R10: If select rises before the 12th rising edge, the frame is dropped and the control word is unchanged. The next frame is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, value driven by the slave |
| sdio_oe_o | output | 1 | Output enable for the shared data line |
| tx_en_i | input | 1 | Transmit enable; a high level blocks writes |
| pwr_lvl_o | output | 2 | Bias level field of the control word |
| gain_lvl_o | output | 6 | Gain step field of the control word |

## Verification
Some rules are checked by the assertions on every cycle:
- the control word is held steady whenever transmit-enable is high, the hold-off is running, or the addressed register is not the control word;
- no commit can start while select is high;
- the bit counter never passes the frame length;
- the output driver turns on only on a serial clock falling edge, and it is released after select rises.

Other behaviour needs the bench's scenarios, because it spans whole frames:
- that the correct bits of a frame land in the correct fields;
- that the change waits for edge twelve;
- that readback returns the stored byte in MSB-first order;
- that a truncated frame leaves no trace on the next frame.

// File: rtl/gainctl_pkg.sv
// Package: gainctl_pkg
// Shared widths and types for the serial gain-control slave.
// The field widths are fixed by the analog core, so they sit here
// rather than as module parameters.
package gainctl_pkg;

    localparam int PWR_W      = 2;
    localparam int GAIN_W     = 6;
    localparam int DATA_W     = PWR_W + GAIN_W;
    localparam int ADDR_W     = 3;
    localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;

    typedef struct packed {
        logic [PWR_W-1:0]  pwr;
        logic [GAIN_W-1:0] gain;
    } ctrl_t;

    typedef enum logic {
        RW_WRITE = 1'b0,
        RW_READ  = 1'b1
    } rw_e;

endpackage

// File: rtl/gainctl_in_sync.sv
// Module: gainctl_in_sync
// Multi-flop synchronizer for a bundle of slow asynchronous pins.
// Assumes every pin stays stable for several system clocks, so bits
// are synchronized one by one with no skew alignment.
// RST_VAL gives the idle level of each pin.
module gainctl_in_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Shift the pin through STAGES flops toward the system domain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
            else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
        end

        assign level_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/gainctl_frame_rx.sv
// Module: gainctl_frame_rx
// Deserializes one frame from the synchronized link.
// Produces a header strobe after the 4th rising edge and a write strobe
// with the data byte after the 12th rising edge.
// Assumes the inputs are already synchronized and that sclk_rise_i is a
// single-cycle strobe. Select high clears the bit count, which drops
// any partial frame.
module gainctl_frame_rx
    import gainctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s_i,
    input  logic              sclk_rise_i,
    input  logic              sdio_s_i,
    output logic              hdr_stb_o,
    output rw_e               rw_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_stb_o,
    output logic [DATA_W-1:0] wr_data_o
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_BITS);

    logic [CNT_W-1:0]  bit_cnt_q;
    logic [DATA_W-1:0] shift_q;
    logic [ADDR_W:0]   header;

    // Header bits: the three already held plus the bit on the line now.
    assign header = {shift_q[ADDR_W-1:0], sdio_s_i};

    // Count edges, shift bits in and raise the header and commit strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shift_q   <= '0;
            hdr_stb_o <= 1'b0;
            rw_o      <= RW_WRITE;
            addr_o    <= '0;
            wr_stb_o  <= 1'b0;
            wr_data_o <= '0;
        end else begin
            hdr_stb_o <= 1'b0;
            wr_stb_o  <= 1'b0;
            if (csn_s_i) begin
                bit_cnt_q <= '0;
            end else if (sclk_rise_i && bit_cnt_q != CNT_FULL) begin
                shift_q   <= {shift_q[DATA_W-2:0], sdio_s_i};
                bit_cnt_q <= bit_cnt_q + 1'b1;
                if (bit_cnt_q == HDR_LAST) begin
                    rw_o      <= rw_e'(header[ADDR_W]);
                    addr_o    <= header[ADDR_W-1:0];
                    hdr_stb_o <= 1'b1;
                end
                if (bit_cnt_q == DATA_LAST) begin
                    wr_data_o <= {shift_q[DATA_W-2:0], sdio_s_i};
                    wr_stb_o  <= (rw_o == RW_WRITE);
                end
            end
        end
    end

    // The edge counter never passes one full frame (R1).
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_q <= CNT_FULL);

    // An idle select forbids a commit on the following cycle (R10).
    assert_no_commit_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s_i |=> !wr_stb_o);

    // A rising select empties the edge counter (R10).
    assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csn_s_i) |=> bit_cnt_q == '0);

endmodule

// File: rtl/gainctl_regs.sv
// Module: gainctl_regs
// Holds the control word and the power-up hold-off counter.
// Decides whether a committed write is accepted, and muxes the readback
// byte for the addressed register.
// Assumes tx_en_i is synchronous to clk.
module gainctl_regs
    import gainctl_pkg::*;
#(
    parameter int               HOLDOFF_CYCLES = 10000,
    parameter logic [ADDR_W-1:0] CTRL_ADDR     = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              tx_en_i,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int HO_W = $clog2(HOLDOFF_CYCLES + 2);
    localparam logic [HO_W-1:0] HO_END = HO_W'(HOLDOFF_CYCLES);

    logic [HO_W-1:0] holdoff_q;
    logic            ready;
    logic            addr_hit;
    logic            wr_ok;

    assign ready    = (holdoff_q == HO_END);
    assign addr_hit = (addr_i == CTRL_ADDR);
    assign wr_ok    = wr_stb_i && addr_hit && !tx_en_i && ready;

    // Count system clocks after reset until the hold-off expires.
    always_ff @(posedge clk) begin
        if (!rst_n)      holdoff_q <= '0;
        else if (!ready) holdoff_q <= holdoff_q + 1'b1;
    end

    // Store an accepted write in the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_o <= '0;
        else if (wr_ok) ctrl_o <= ctrl_t'(wr_data_i);
    end

    // Readback: the control word at its address, zero elsewhere.
    always_comb begin
        rd_data_o = addr_hit ? DATA_W'(ctrl_o) : '0;
    end

    // Transmit enable freezes the control word (R5).
    assert_txen_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_i |=> $stable(ctrl_o));

    // The hold-off freezes the control word (R6).
    assert_holdoff_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(ctrl_o));

    // A commit aimed at another address leaves the word alone (R9).
    assert_foreign_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && !addr_hit) |=> $stable(ctrl_o));

endmodule

// File: rtl/gainctl_rd_drive.sv
// Module: gainctl_rd_drive
// Serializes the readback byte onto the shared data line.
// The enable turns on at the first serial clock falling edge after a
// read header, and each later falling edge moves to the next bit.
// Assumes hdr_stb_i arrives before that falling edge.
module gainctl_rd_drive
    import gainctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s_i,
    input  logic              sclk_fall_i,
    input  logic              hdr_stb_i,
    input  rw_e               rw_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              sdio_o,
    output logic              sdio_oe_o
);

    logic              armed_q;
    logic [DATA_W-1:0] out_q;

    // Load the byte on a read header, then step it out on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            sdio_oe_o <= 1'b0;
            out_q     <= '0;
        end else if (csn_s_i) begin
            armed_q   <= 1'b0;
            sdio_oe_o <= 1'b0;
        end else if (hdr_stb_i) begin
            armed_q   <= (rw_i == RW_READ);
            sdio_oe_o <= 1'b0;
            out_q     <= rd_data_i;
        end else if (sclk_fall_i && armed_q) begin
            if (!sdio_oe_o) sdio_oe_o <= 1'b1;
            else            out_q     <= {out_q[DATA_W-2:0], 1'b0};
        end
    end

    assign sdio_o = sdio_oe_o & out_q[DATA_W-1];

    // The driver only turns on at a serial clock falling edge (R7).
    assert_oe_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe_o) |-> $past(sclk_fall_i));

    // An idle select releases the line on the next cycle (R8).
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s_i |=> !sdio_oe_o);

endmodule

// File: rtl/gainctl_spi_slave.sv
// Module: gainctl_spi_slave (top)
// Three-wire serial slave that owns the bias/gain control word.
// It synchronizes the link pins and detects serial clock edges, then
// ties the frame receiver, the register store and the readback driver
// together.
// Assumes the serial clock runs well below clk/4.
module gainctl_spi_slave
    import gainctl_pkg::*;
#(
    parameter int                HOLDOFF_CYCLES = 10000,
    parameter int                SYNC_STAGES    = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR      = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe_o,
    input  logic              tx_en_i,
    output logic [PWR_W-1:0]  pwr_lvl_o,
    output logic [GAIN_W-1:0] gain_lvl_o
);

    localparam int PIN_CSN  = 2;
    localparam int PIN_SCLK = 1;
    localparam int PIN_SDIO = 0;

    logic [2:0]        pins_s;
    logic              sclk_prev_q;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              hdr_stb;
    rw_e               frame_rw;
    logic [ADDR_W-1:0] frame_addr;
    logic              wr_stb;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    ctrl_t             ctrl;

    gainctl_in_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({csn_i, sclk_i, sdio_i}),
        .level_o(pins_s)
    );

    // Keep the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= pins_s[PIN_SCLK];
    end

    assign sclk_rise = pins_s[PIN_SCLK] & ~sclk_prev_q;
    assign sclk_fall = ~pins_s[PIN_SCLK] & sclk_prev_q;

    gainctl_frame_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .csn_s_i    (pins_s[PIN_CSN]),
        .sclk_rise_i(sclk_rise),
        .sdio_s_i   (pins_s[PIN_SDIO]),
        .hdr_stb_o  (hdr_stb),
        .rw_o       (frame_rw),
        .addr_o     (frame_addr),
        .wr_stb_o   (wr_stb),
        .wr_data_o  (wr_data)
    );

    gainctl_regs #(
        .HOLDOFF_CYCLES(HOLDOFF_CYCLES),
        .CTRL_ADDR     (CTRL_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb_i (wr_stb),
        .addr_i   (frame_addr),
        .wr_data_i(wr_data),
        .tx_en_i  (tx_en_i),
        .ctrl_o   (ctrl),
        .rd_data_o(rd_data)
    );

    gainctl_rd_drive u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .csn_s_i    (pins_s[PIN_CSN]),
        .sclk_fall_i(sclk_fall),
        .hdr_stb_i  (hdr_stb),
        .rw_i       (frame_rw),
        .rd_data_i  (rd_data),
        .sdio_o     (sdio_o),
        .sdio_oe_o  (sdio_oe_o)
    );

    assign pwr_lvl_o  = ctrl.pwr;
    assign gain_lvl_o = ctrl.gain;

    // Outputs move only on a commit cycle (R3).
    assert_change_on_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable({pwr_lvl_o, gain_lvl_o}));

endmodule

// File: tb/gainctl_spi_slave_test.sv
// Bench for gainctl_spi_slave: a vector table of frames walked by one
// loop, then directed reset, hold-off, edge-12 and abort scenarios.
module gainctl_spi_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int HOLDOFF    = 300;
    localparam int NVEC       = 10;

    // Fields: [20] dir, [19:17] addr, [16:9] data, [8] tx_en, [7:0] expected.
    localparam logic [20:0] VECS [NVEC] = '{
        {1'b0, 3'd0, 8'hC5, 1'b0, 8'hC5},
        {1'b1, 3'd0, 8'h00, 1'b0, 8'hC5},
        {1'b0, 3'd0, 8'h3A, 1'b1, 8'hC5},
        {1'b1, 3'd0, 8'h00, 1'b0, 8'hC5},
        {1'b0, 3'd3, 8'hFF, 1'b0, 8'hC5},
        {1'b1, 3'd5, 8'h00, 1'b0, 8'h00},
        {1'b0, 3'd0, 8'h7E, 1'b0, 8'h7E},
        {1'b1, 3'd0, 8'h00, 1'b0, 8'h7E},
        {1'b0, 3'd0, 8'h81, 1'b0, 8'h81},
        {1'b1, 3'd7, 8'h00, 1'b0, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       csn = 1'b1;
    logic       m_en = 1'b0;
    logic       m_bit = 1'b0;
    logic       tx_en = 1'b0;
    logic       sdio_bus;
    logic       s_sdo;
    logic       s_oe;
    logic [1:0] pwr;
    logic [5:0] gain;
    int         checks = 0;
    int         fails = 0;

    // A high pull-up when no side drives the line.
    assign sdio_bus = s_oe ? s_sdo : (m_en ? m_bit : 1'b1);

    always #(CLK_PERIOD / 2) clk = ~clk;

    gainctl_spi_slave #(.HOLDOFF_CYCLES(HOLDOFF)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .csn_i     (csn),
        .sdio_i    (sdio_bus),
        .sdio_o    (s_sdo),
        .sdio_oe_o (s_oe),
        .tx_en_i   (tx_en),
        .pwr_lvl_o (pwr),
        .gain_lvl_o(gain)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of nbits edges. mid_chk checks outputs around edges 11 and 12.
    task automatic frame(input bit rw, input logic [2:0] addr, input logic [7:0] data,
                         input int nbits, input bit mid_chk, input logic [7:0] oldv,
                         input logic [7:0] newv, output logic [7:0] rdata,
                         output bit oe_ok);
        logic [11:0] word;
        word  = {rw, addr, data};
        rdata = '0;
        oe_ok = 1'b1;
        @(negedge clk);
        csn = 1'b0;
        idle(HALF);
        for (int i = 0; i < nbits; i++) begin
            if (rw && i >= 4) m_en = 1'b0;
            else begin
                m_en  = 1'b1;
                m_bit = word[11 - i];
            end
            idle(HALF);
            if (rw) begin
                if (i < 4 && s_oe) oe_ok = 1'b0;
                if (i >= 4) begin
                    if (!s_oe) oe_ok = 1'b0;
                    rdata = {rdata[6:0], sdio_bus};
                end
            end
            sclk = 1'b1;
            idle(HALF);
            if (mid_chk && i == 10)
                chk({pwr, gain} == oldv, "R3 before edge 12", {pwr, gain}, oldv);
            if (mid_chk && i == 11)
                chk({pwr, gain} == newv, "R3 after edge 12", {pwr, gain}, newv);
            sclk = 1'b0;
        end
        idle(HALF);
        m_en = 1'b0;
        csn  = 1'b1;
        idle(HALF);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        bit         oek;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R4: reset state.
        chk({pwr, gain} == 8'h00, "R4 control word", {pwr, gain}, 0);
        chk(s_oe == 1'b0, "R4 driver off", s_oe, 0);

        // R6: a write inside the hold-off window is dropped.
        frame(1'b0, 3'd0, 8'hEE, 12, 1'b0, 8'h00, 8'h00, rd, oek);
        chk({pwr, gain} == 8'h00, "R6 write during hold-off", {pwr, gain}, 0);
        idle(HOLDOFF);

        // Vector table: R1 framing, R2 store/fields, R5 tx gate, R7 readback, R9 addresses.
        for (int v = 0; v < NVEC; v++) begin
            logic [20:0] e;
            string       tag;
            e = VECS[v];
            tag = e[20] ? "R7/R1 readback" : (e[8] ? "R5 tx-enable block" :
                  (e[19:17] != 3'd0 ? "R9 foreign write" : "R2 write"));
            if (e[20] && e[19:17] != 3'd0) tag = "R9 foreign read";
            tx_en = e[8];
            frame(e[20], e[19:17], e[16:9], 12, 1'b0, 8'h00, 8'h00, rd, oek);
            tx_en = 1'b0;
            if (e[20]) begin
                chk(rd == e[7:0], tag, rd, e[7:0]);
                chk(oek, "R7 driver window", oek, 1);
                chk(s_oe == 1'b0, "R8 release after select", s_oe, 0);
            end else begin
                chk(pwr == e[7:6], {tag, " R2 power field"}, pwr, e[7:6]);
                chk(gain == e[5:0], {tag, " R2 gain field"}, gain, e[5:0]);
            end
        end

        // R3: the change waits for the twelfth edge.
        frame(1'b0, 3'd0, 8'h5B, 12, 1'b1, 8'h81, 8'h5B, rd, oek);

        // R10: a truncated frame changes nothing, and the next frame decodes cleanly.
        frame(1'b0, 3'd0, 8'h24, 7, 1'b0, 8'h00, 8'h00, rd, oek);
        chk({pwr, gain} == 8'h5B, "R10 aborted write", {pwr, gain}, 8'h5B);
        frame(1'b0, 3'd0, 8'h24, 11, 1'b0, 8'h00, 8'h00, rd, oek);
        chk({pwr, gain} == 8'h5B, "R10 eleven-edge frame", {pwr, gain}, 8'h5B);
        frame(1'b0, 3'd0, 8'h24, 12, 1'b0, 8'h00, 8'h00, rd, oek);
        chk({pwr, gain} == 8'h24, "R10 frame after abort", {pwr, gain}, 8'h24);
        frame(1'b1, 3'd0, 8'h00, 12, 1'b0, 8'h00, 8'h00, rd, oek);
        chk(rd == 8'h24, "R7 readback after abort", rd, 8'h24);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule